// File: doc/BRIEF.md
# Weighted Activity Power Proxy

This block turns microarchitectural event pulses into a digital estimate of switching power for a group of cores. Each core has a bank of event counters that run over a fixed sampling interval whose length is set by the counter width. When an interval closes, the counts are frozen and a single-multiplier accumulator forms the sum of every count times a programmable 8-bit weight. It then sends that sum to the chip-level side over a one-wire serial link.

Each core offers two estimates from the same counter bank. The long-term estimate takes all sixteen counters. The short-term estimate takes the eight even-numbered counters and is ready eight cycles sooner, at some cost in accuracy. A mode pin picks which one is forwarded. A chip-level receiver deserialises each core's frame, adds all per-core values in an adder tree, and presents a 32-bit chip total together with a one-cycle strobe.

The total output is a plain valid pulse with no ready. The sink has to take every strobe. A new value arrives at most once per interval per core, so there is nothing to buffer and back-pressure is not supported.

Top module: `pp_power_proxy`

## Requirements
- R1: While `rst_n` is low, `total_o` is 0 and `total_vld_o` is 0. All weights reset to zero, so every total is 0 until weights are written.
- R2: An interval lasts 2^CW cycles (64 by default). An event input that is high in a cycle adds one to that event's count for the current interval. Counts start from zero in every interval.
- R3: A count saturates at 2^CW-1 (63) and never wraps. An event held high for a whole interval therefore counts 63.
- R4: With `mode_i`=0 (long-term), a core's value is the sum over all 16 events of count times weight.
- R5: With `mode_i`=1 (short-term), a core's value sums only events 0, 2, 4, ..., 14. The odd events have no effect.
- R6: A write with `wt_wr_i`=1 stores `wt_data_i` as the weight of event `wt_idx_i` of core `wt_core_i` only. It applies to intervals closed after the write.
- R7: `total_o` is the exact 32-bit sum of the latest value of every core. Event bit `c*16+i` of `ev_i` is event i of core c.
- R8: `total_vld_o` is a one-cycle pulse. `total_o` changes only in a cycle where `total_vld_o` is high. With a steady mode, successive pulses are exactly 2^CW cycles apart.
- R9: The short-term result reaches `total_o` exactly 8 cycles earlier in the interval than the long-term result. The serial frame has the same length in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_i | input | NCORES*NEV | Event pulses, bit c*NEV+i is event i of core c |
| mode_i | input | 1 | 0 selects the long-term estimate, 1 selects the short-term estimate |
| wt_wr_i | input | 1 | Weight write strobe |
| wt_core_i | input | max(1,clog2(NCORES)) | Core addressed by the write |
| wt_idx_i | input | clog2(NEV) | Event index addressed by the write |
| wt_data_i | input | WW | Weight value |
| total_o | output | TW | Chip-level weighted activity total |
| total_vld_o | output | 1 | One-cycle strobe when total_o updates |

## Verification
The hardest cases to reach are exact counts within an interval whose phase cannot be seen at the ports, and above all the saturation limit and the 8-cycle phase shift between modes. To get there, the stimulus drives each event with a period that divides the interval length (every cycle, every 2nd, 4th or 8th). Every interval then sees the same count whatever its alignment. After each configuration change, the checks take the third result, so that no partially configured interval is counted. The mode-latency check compares where the strobe falls, modulo the interval, before and after a mode switch.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic {
    PX_LONG  = 1'b0,
    PX_SHORT = 1'b1
  } px_mode_e;
endpackage

// File: rtl/pp_event_bank.sv
module pp_event_bank #(
  parameter int NEV = 16,
  parameter int CW  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NEV-1:0]          ev,
  output logic [NEV-1:0][CW-1:0]  snap_o,
  output logic                    snap_stb_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] tick;
  logic          last;

  assign last = (tick == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick       <= '0;
      snap_stb_o <= 1'b0;
    end else begin
      tick       <= tick + 1'b1;
      snap_stb_o <= last;
    end
  end

  for (genvar i = 0; i < NEV; i++) begin : g_ctr
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_n;
    logic [CW-1:0] snap_q;

    // saturating increment
    assign cnt_n = (ev[i] && (cnt_q != CMAX)) ? cnt_q + 1'b1 : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        snap_q <= '0;
      end else if (last) begin
        snap_q <= cnt_n;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_n;
      end
    end

    assign snap_o[i] = snap_q;
  end
endmodule

// File: rtl/pp_mac.sv
module pp_mac
  import pp_pkg::*;
#(
  parameter int NEV  = 16,
  parameter int CW   = 6,
  parameter int WW   = 8,
  parameter int SUMW = CW + WW + $clog2(NEV)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NEV-1:0][CW-1:0]  snap,
  input  logic                    snap_stb,
  input  px_mode_e                mode,
  input  logic                    wr_en,
  input  logic [$clog2(NEV)-1:0]  wr_idx,
  input  logic [WW-1:0]           wr_data,
  output logic [SUMW-1:0]         res_o,
  output logic                    res_vld_o
);
  localparam int IW = $clog2(NEV);
  localparam logic [IW-1:0] LAST_LONG  = IW'(NEV - 1);
  localparam logic [IW-1:0] LAST_SHORT = IW'(NEV / 2 - 1);

  logic [NEV-1:0][WW-1:0] wt;
  logic                   busy;
  logic [IW-1:0]          idx;
  logic [SUMW-1:0]        acc;
  px_mode_e               mode_q;

  logic [IW-1:0]          sel;
  logic [IW-1:0]          last_idx;
  logic [CW+WW-1:0]       prod;
  logic [SUMW-1:0]        acc_n;

  // short mode walks the even-numbered counters only
  assign sel      = (mode_q == PX_SHORT) ? (idx << 1) : idx;
  assign last_idx = (mode_q == PX_SHORT) ? LAST_SHORT : LAST_LONG;
  assign prod     = snap[sel] * wt[sel];
  assign acc_n    = acc + SUMW'(prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt <= '0;
    end else if (wr_en) begin
      wt[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      acc       <= '0;
      mode_q    <= PX_LONG;
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= 1'b0;
      if (snap_stb) begin
        busy   <= 1'b1;
        idx    <= '0;
        acc    <= '0;
        mode_q <= mode;
      end else if (busy) begin
        acc <= acc_n;
        idx <= idx + 1'b1;
        if (idx == last_idx) begin
          busy      <= 1'b0;
          res_o     <= acc_n;
          res_vld_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pp_ser_tx.sv
module pp_ser_tx #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] data,
  output logic          line_o
);
  localparam int FW = DW + 1;
  localparam int LW = $clog2(FW + 1);

  logic [FW-1:0] shreg;
  logic [LW-1:0] left;

  // frame: one start bit, then DW data bits MSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (load && (left == '0)) begin
      shreg <= {1'b1, data};
      left  <= LW'(FW);
    end else if (left != '0) begin
      shreg <= shreg << 1;
      left  <= left - 1'b1;
    end
  end

  assign line_o = (left != '0) && shreg[FW-1];
endmodule

// File: rtl/pp_chip_rx.sv
module pp_chip_rx #(
  parameter int NC = 2,
  parameter int DW = 18,
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] lines,
  output logic [TW-1:0] total_o,
  output logic          valid_o
);
  localparam int CNW = $clog2(DW);
  localparam int LV  = $clog2(NC);
  localparam int P   = 1 << LV;

  logic [NC-1:0] got;
  logic [TW-1:0] node [2*P-1];

  for (genvar c = 0; c < NC; c++) begin : g_rx
    logic           busy;
    logic [CNW-1:0] cnt;
    logic [DW-2:0]  sh;
    logic [DW-1:0]  val;
    logic           got_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy  <= 1'b0;
        cnt   <= '0;
        sh    <= '0;
        val   <= '0;
        got_q <= 1'b0;
      end else begin
        got_q <= 1'b0;
        if (!busy) begin
          if (lines[c]) begin
            busy <= 1'b1;
            cnt  <= '0;
          end
        end else begin
          sh  <= {sh[DW-3:0], lines[c]};
          cnt <= cnt + 1'b1;
          if (cnt == CNW'(DW - 1)) begin
            busy  <= 1'b0;
            val   <= {sh, lines[c]};
            got_q <= 1'b1;
          end
        end
      end
    end

    assign got[c]          = got_q;
    assign node[P - 1 + c] = TW'(val);
  end

  for (genvar k = NC; k < P; k++) begin : g_pad
    assign node[P - 1 + k] = '0;
  end

  for (genvar n = 0; n < P - 1; n++) begin : g_tree
    assign node[n] = node[2*n + 1] + node[2*n + 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= |got;
      if (|got) total_o <= node[0];
    end
  end
endmodule

// File: rtl/pp_power_proxy.sv
module pp_power_proxy
  import pp_pkg::*;
#(
  parameter int NCORES = 2,
  parameter int NEV    = 16,
  parameter int CW     = 6,
  parameter int WW     = 8,
  parameter int TW     = 32
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [NCORES*NEV-1:0]                    ev_i,
  input  logic                                     mode_i,
  input  logic                                     wt_wr_i,
  input  logic [(NCORES > 1 ? $clog2(NCORES) : 1)-1:0] wt_core_i,
  input  logic [$clog2(NEV)-1:0]                   wt_idx_i,
  input  logic [WW-1:0]                            wt_data_i,
  output logic [TW-1:0]                            total_o,
  output logic                                     total_vld_o
);
  localparam int CIW  = (NCORES > 1) ? $clog2(NCORES) : 1;
  localparam int SUMW = CW + WW + $clog2(NEV);

  px_mode_e          mode;
  logic [NCORES-1:0] lines;

  assign mode = px_mode_e'(mode_i);

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic [NEV-1:0][CW-1:0] snap;
    logic                   snap_stb;
    logic [SUMW-1:0]        res;
    logic                   res_vld;
    logic                   wr_hit;

    assign wr_hit = wt_wr_i && (wt_core_i == CIW'(c));

    pp_event_bank #(.NEV(NEV), .CW(CW)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev         (ev_i[c*NEV +: NEV]),
      .snap_o     (snap),
      .snap_stb_o (snap_stb)
    );

    pp_mac #(.NEV(NEV), .CW(CW), .WW(WW), .SUMW(SUMW)) u_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .snap      (snap),
      .snap_stb  (snap_stb),
      .mode      (mode),
      .wr_en     (wr_hit),
      .wr_idx    (wt_idx_i),
      .wr_data   (wt_data_i),
      .res_o     (res),
      .res_vld_o (res_vld)
    );

    pp_ser_tx #(.DW(SUMW)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (res_vld),
      .data   (res),
      .line_o (lines[c])
    );
  end

  pp_chip_rx #(.NC(NCORES), .DW(SUMW), .TW(TW)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   (lines),
    .total_o (total_o),
    .valid_o (total_vld_o)
  );
endmodule

// File: rtl/pp_power_proxy_chk.sv
module pp_power_proxy_chk #(
  parameter int NCORES = 2,
  parameter int NEV    = 16,
  parameter int CW     = 6,
  parameter int WW     = 8,
  parameter int TW     = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vld,
  input logic [TW-1:0] total
);
  localparam int PER  = 1 << CW;
  localparam longint MAXT = longint'(NCORES) * NEV * ((1 << CW) - 1) * ((1 << WW) - 1);
  localparam int GW = CW + 2;

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (vld) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != '1) begin
      gap  <= gap + 1'b1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (total == '0) && !vld);

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> $stable(total));

  // mode switches move one strobe by at most NEV/2 cycles
  p_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && seen) |-> ((int'(gap) >= PER - 1 - NEV/2) && (int'(gap) <= PER - 1 + NEV/2)));

  p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (longint'(total) <= MAXT));
endmodule

bind pp_power_proxy pp_power_proxy_chk #(
  .NCORES(NCORES), .NEV(NEV), .CW(CW), .WW(WW), .TW(TW)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .vld   (total_vld_o),
  .total (total_o)
);

// File: tb/sim_pp_power_proxy.sv
module sim_pp_power_proxy;
  localparam int NC  = 2;
  localparam int NEV = 16;
  localparam int PER = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC*NEV-1:0] ev = '0;
  logic          mode = 1'b0;
  logic          wr = 1'b0;
  logic [0:0]    wcore = '0;
  logic [3:0]    widx = '0;
  logic [7:0]    wdata = '0;
  logic [31:0]   total;
  logic          vld;

  int per [NC][NEV];
  int wb  [NC][NEV];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  pp_power_proxy u0 (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .mode_i(mode), .wt_wr_i(wr),
    .wt_core_i(wcore), .wt_idx_i(widx), .wt_data_i(wdata),
    .total_o(total), .total_vld_o(vld)
  );

  always #5 clk = ~clk;

  // periodic event stimulus; periods divide the interval so counts are phase-free
  always @(negedge clk) begin
    cyc++;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NEV; i++)
        ev[c*NEV+i] = (per[c][i] != 0) && ((cyc % per[c][i]) == 0);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint cnt_of(input int p);
    if (p == 0) return 0;
    if (p == 1) return PER - 1;
    return PER / p;
  endfunction

  function automatic longint expect_total(input bit short_m);
    longint s = 0;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NEV; i++)
        if (!short_m || (i % 2 == 0)) s += cnt_of(per[c][i]) * wb[c][i];
    return s;
  endfunction

  task automatic set_w(input int c, input int i, input int d);
    @(negedge clk);
    wr = 1'b1; wcore = 1'(c); widx = 4'(i); wdata = 8'(d);
    @(negedge clk);
    wr = 1'b0;
    wb[c][i] = d;
  endtask

  task automatic clear_cfg();
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NEV; i++) per[c][i] = 0;
  endtask

  task automatic wait_vld(output int at);
    at = -1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (vld) begin at = cyc; return; end
    end
    check(1'b0, "R8 strobe timeout", 0, 1);
  endtask

  task automatic settle_check(input string req, input longint exp);
    int at;
    for (int k = 0; k < 3; k++) wait_vld(at);
    check(longint'(total) == exp, req, longint'(total), exp);
  endtask

  task automatic t_reset();
    check(total == 0, "R1 total in reset", longint'(total), 0);
    check(vld == 1'b0, "R1 strobe in reset", longint'(vld), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NEV; i++) per[c][i] = 1;
    settle_check("R1 zero weights after reset", 0);
  endtask

  task automatic t_long();
    clear_cfg();
    for (int i = 0; i < NEV; i++) begin set_w(0, i, i + 1); per[0][i] = 2; end
    settle_check("R4 long sum period 2", expect_total(0));
    for (int i = 0; i < NEV; i++) per[0][i] = 4;
    settle_check("R2 count period 4", expect_total(0));
    for (int i = 0; i < NEV; i++) per[0][i] = (i < 8) ? 8 : 0;
    settle_check("R2 mixed counts", expect_total(0));
  endtask

  task automatic t_sat();
    for (int i = 0; i < NEV; i++) per[0][i] = 1;
    settle_check("R3 saturation at 63", expect_total(0));
    check(expect_total(0) == 63 * 136, "R3 model", expect_total(0), 63 * 136);
  endtask

  task automatic t_percore();
    for (int i = 0; i < NEV; i++) begin set_w(1, i, 3); per[1][i] = 1; end
    settle_check("R6 R7 two cores summed", expect_total(0));
    set_w(1, 5, 0);
    settle_check("R6 single weight write", expect_total(0));
  endtask

  task automatic t_short();
    mode = 1'b1;
    for (int i = 0; i < NEV; i++) per[0][i] = (i % 3 == 0) ? 2 : 1;
    settle_check("R5 short subset", expect_total(1));
    clear_cfg();
    for (int i = 1; i < NEV; i += 2) begin per[0][i] = 1; per[1][i] = 1; end
    settle_check("R5 odd events ignored", 0);
    mode = 1'b0;
    settle_check("R4 odd events in long mode", expect_total(0));
  endtask

  task automatic t_period();
    int a, b;
    wait_vld(a);
    @(negedge clk);
    check(vld == 1'b0, "R8 one-cycle strobe", longint'(vld), 0);
    wait_vld(b);
    check(b - a == PER, "R8 period", b - a, PER);
  endtask

  task automatic t_latency();
    int a, b, d;
    mode = 1'b0;
    for (int k = 0; k < 3; k++) wait_vld(a);
    mode = 1'b1;
    for (int k = 0; k < 3; k++) wait_vld(b);
    d = ((a - b) % PER + PER) % PER;
    check(d == 8, "R9 short result 8 cycles earlier", d, 8);
    mode = 1'b0;
  endtask

  task automatic t_max();
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NEV; i++) begin set_w(c, i, 255); per[c][i] = 1; end
    settle_check("R7 full-scale total", 514080);
    check(expect_total(0) == 514080, "R7 model", expect_total(0), 514080);
  endtask

  initial begin
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NEV; i++) begin per[c][i] = 0; wb[c][i] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    t_long();
    t_sat();
    t_percore();
    t_short();
    t_period();
    t_latency();
    t_max();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule